// File: doc/BRIEF.md
# Direct-Mapped Write-Back Backup Cache Controller

This block sits between a processor and a shared system bus. It manages a large external backup cache built as a direct-mapped, physically addressed, write-back array. Each line holds one 64-byte block, stored as four 144-bit beats: 128 data bits plus 16 check bits, passed through unchanged. A tag table keeps a tag, a valid flag and a dirty flag for each line. Every processor request is looked up in that table. A hit is served from the data RAM, which is a plain synchronous RAM with one cycle of read latency. A miss first writes back the old line if it is dirty, then fetches the new block from the bus.

All four data-carrying interfaces use valid/ready. The processor request, the bus command, the write-back beats and the response are each transferred on a rising clock edge where valid and ready are both high. A sender holds its valid and payload steady until that edge. The fill interface follows the same rule: `fill_ready` is high for the whole fill window. Each fill beat goes straight into the data RAM on the edge where it is accepted, so no staging buffer is needed.

Top module: `cache_ctrl`

## Requirements
- R1: After reset every line is invalid and clean, so the first access to each line misses. While idle, `req_ready` is 1 and `cmd_valid`, `wb_valid`, `fill_ready` and `rsp_valid` are all 0.
- R2: `req_addr` carries physical address bits [35:4]. Its bits [1:0] select the beat within the block, the next INDEX_W bits select the line, and the remaining high bits form the tag. `cmd_addr` is the 36-bit block address {tag, index, 6'b0}.
- R3: A read whose line is valid with an equal tag returns the stored beat with `rsp_hit`=1 and issues no bus command.
- R4: A miss on a line that is invalid or clean issues exactly one command, code 4'h1 (read miss), carrying the new block address. Four fill beats follow and are stored as beats 0,1,2,3 in arrival order. The response then has `rsp_hit`=0.
- R5: A miss on a valid dirty line first issues code 4'h3 (victim write) with the old block's address. Four write-back beats follow in order 0..3, carrying the stored data. Only after the fourth beat is the read miss for the new block issued.
- R6: A write hit updates only the addressed beat in the cache and marks the line dirty. It causes no bus traffic, and later reads return the new data.
- R7: A write miss fills the block as in R4 or R5, then merges the written beat and marks the line dirty.
- R8: A read response carries the addressed beat. A write response echoes the written data.
- R9: A command, a write-back beat and a response each stay valid with unchanged payload until they are accepted. New requests are taken only while idle.
- R10: A fill writes the tag and sets the valid flag after the last beat, and it leaves the line clean. Evicting a line that has been filled but never written produces no victim write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the system bus |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Controller can accept a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Physical address bits [35:4] of the beat |
| req_wdata | input | 144 | Write beat (data plus check bits) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Processor accepts the response |
| rsp_rdata | output | 144 | Read beat, or the echoed write beat |
| rsp_hit | output | 1 | 1 if served without any bus traffic |
| cmd_valid | output | 1 | Bus command valid |
| cmd_ready | input | 1 | Bus accepts the command |
| cmd_code | output | 4 | 4'h1 read miss, 4'h3 victim write |
| cmd_addr | output | 36 | Block address of the command |
| wb_valid | output | 1 | Write-back beat valid |
| wb_ready | input | 1 | Bus accepts the write-back beat |
| wb_data | output | 144 | Write-back beat |
| fill_valid | input | 1 | Fill beat valid |
| fill_ready | output | 1 | Controller is waiting for fill beats |
| fill_data | input | 144 | Fill beat |

## Verification
The bench uses a four-line configuration and runs a bench-side model of the tag table, the line contents and main memory. The first sweep reads every line cold, which separates an invalid-line miss from a hit. Sweeping every beat of every line then checks the index and beat decode. Re-reading lines with a second tag after write hits separates a dirty eviction, which must show the victim data, from a clean eviction, which must produce no victim command. Write misses and toggling back-pressure on every ready and fill valid check that data merges correctly and that payloads stay stable under stalls. Re-fetching written-back blocks confirms that the victim beats reached memory intact.

// File: rtl/cache_ctrl_pkg.sv
package cache_ctrl_pkg;

  localparam logic [3:0] CMD_NONE      = 4'h0;
  localparam logic [3:0] CMD_READ_MISS = 4'h1;
  localparam logic [3:0] CMD_VICTIM_WR = 4'h3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOKUP,
    S_VCMD,
    S_WBRD,
    S_WBOUT,
    S_RCMD,
    S_FILL,
    S_RESP
  } ctl_state_e;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int INDEX_W = 8,
  parameter int TAG_W   = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic               rd_valid,
  output logic               rd_dirty,
  output logic [TAG_W-1:0]   rd_tag,
  input  logic               fill_done,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic               mark_dirty
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  // valid/dirty flags reset; the tag array does not need to
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_done) begin
      valid_q[rd_idx] <= 1'b1;
      dirty_q[rd_idx] <= 1'b0;
    end else if (mark_dirty) begin
      dirty_q[rd_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) tag_mem[rd_idx] <= fill_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];

endmodule

// File: rtl/cache_lookup.sv
module cache_lookup #(
  parameter int TAG_W = 22
) (
  input  logic             line_valid,
  input  logic             line_dirty,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [TAG_W-1:0] want_tag,
  output logic             hit,
  output logic             evict_dirty
);
  always_comb begin
    hit         = line_valid && (line_tag == want_tag);
    evict_dirty = !hit && line_valid && line_dirty;
  end
endmodule

// File: rtl/cache_data_ram.sv
module cache_data_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 144
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // one-cycle read latency; the output register holds between reads
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_ctrl_pkg::*;
#(
  parameter int ADDR_W          = 36,
  parameter int DATA_W          = 144,
  parameter int INDEX_W         = 8,
  parameter int BEATS_LOG2      = 2,
  parameter int BEAT_BYTES_LOG2 = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic                              req_write,
  input  logic [ADDR_W-BEAT_BYTES_LOG2-1:0] req_addr,
  input  logic [DATA_W-1:0]                 req_wdata,
  output logic                              rsp_valid,
  input  logic                              rsp_ready,
  output logic [DATA_W-1:0]                 rsp_rdata,
  output logic                              rsp_hit,
  output logic                              cmd_valid,
  input  logic                              cmd_ready,
  output logic [3:0]                        cmd_code,
  output logic [ADDR_W-1:0]                 cmd_addr,
  output logic                              wb_valid,
  input  logic                              wb_ready,
  output logic [DATA_W-1:0]                 wb_data,
  input  logic                              fill_valid,
  output logic                              fill_ready,
  input  logic [DATA_W-1:0]                 fill_data
);
  localparam int OFF_W  = BEATS_LOG2 + BEAT_BYTES_LOG2;
  localparam int TAG_W  = ADDR_W - OFF_W - INDEX_W;
  localparam int BADR_W = ADDR_W - BEAT_BYTES_LOG2;
  localparam int RAM_AW = INDEX_W + BEATS_LOG2;
  localparam logic [BEATS_LOG2-1:0] LAST_BEAT = {BEATS_LOG2{1'b1}};

  ctl_state_e              state_q;
  logic                    write_q;
  logic [BADR_W-1:0]       addr_q;
  logic [DATA_W-1:0]       wdata_q;
  logic [BEATS_LOG2-1:0]   beat_cnt_q;
  logic                    missed_q;

  logic [INDEX_W-1:0]      idx;
  logic [TAG_W-1:0]        tag_req;
  logic [BEATS_LOG2-1:0]   beat_req;

  logic                    line_valid, line_dirty;
  logic [TAG_W-1:0]        line_tag;
  logic                    hit, evict_dirty;
  logic                    fill_done, mark_dirty;

  logic                    ram_en, ram_we;
  logic [RAM_AW-1:0]       ram_addr;
  logic [DATA_W-1:0]       ram_wdata, ram_q;

  // request address split: {tag, index, beat}
  assign beat_req = addr_q[BEATS_LOG2-1:0];
  assign idx      = addr_q[BEATS_LOG2 +: INDEX_W];
  assign tag_req  = addr_q[BADR_W-1 -: TAG_W];

  cache_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (idx),
    .rd_valid   (line_valid),
    .rd_dirty   (line_dirty),
    .rd_tag     (line_tag),
    .fill_done  (fill_done),
    .fill_tag   (tag_req),
    .mark_dirty (mark_dirty)
  );

  cache_lookup #(.TAG_W(TAG_W)) u_lookup (
    .line_valid  (line_valid),
    .line_dirty  (line_dirty),
    .line_tag    (line_tag),
    .want_tag    (tag_req),
    .hit         (hit),
    .evict_dirty (evict_dirty)
  );

  cache_data_ram #(.ADDR_W(RAM_AW), .DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_q)
  );

  // tag table updates
  assign fill_done  = (state_q == S_FILL) && fill_valid && (beat_cnt_q == LAST_BEAT);
  assign mark_dirty = (state_q == S_LOOKUP) && hit && write_q;

  // data RAM port steering
  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = {idx, beat_req};
    ram_wdata = wdata_q;
    unique case (state_q)
      S_LOOKUP: begin
        ram_en = hit;
        ram_we = write_q;
      end
      S_WBRD: begin
        ram_en   = 1'b1;
        ram_addr = {idx, beat_cnt_q};
      end
      S_FILL: begin
        ram_en    = fill_valid;
        ram_we    = 1'b1;
        ram_addr  = {idx, beat_cnt_q};
        ram_wdata = fill_data;
      end
      default: ;
    endcase
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      write_q    <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      beat_cnt_q <= '0;
      missed_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          write_q  <= req_write;
          addr_q   <= req_addr;
          wdata_q  <= req_wdata;
          missed_q <= 1'b0;
          state_q  <= S_LOOKUP;
        end
        S_LOOKUP: begin
          if (hit) begin
            state_q <= S_RESP;
          end else begin
            missed_q <= 1'b1;
            state_q  <= evict_dirty ? S_VCMD : S_RCMD;
          end
        end
        S_VCMD: if (cmd_ready) begin
          beat_cnt_q <= '0;
          state_q    <= S_WBRD;
        end
        S_WBRD: state_q <= S_WBOUT;
        S_WBOUT: if (wb_ready) begin
          if (beat_cnt_q == LAST_BEAT) begin
            state_q <= S_RCMD;
          end else begin
            beat_cnt_q <= beat_cnt_q + 1'b1;
            state_q    <= S_WBRD;
          end
        end
        S_RCMD: if (cmd_ready) begin
          beat_cnt_q <= '0;
          state_q    <= S_FILL;
        end
        S_FILL: if (fill_valid) begin
          beat_cnt_q <= beat_cnt_q + 1'b1;
          if (beat_cnt_q == LAST_BEAT) state_q <= S_LOOKUP;
        end
        S_RESP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // port outputs, all decoded from registered state
  assign req_ready  = (state_q == S_IDLE);
  assign cmd_valid  = (state_q == S_VCMD) || (state_q == S_RCMD);
  assign cmd_code   = (state_q == S_VCMD) ? CMD_VICTIM_WR :
                      (state_q == S_RCMD) ? CMD_READ_MISS : CMD_NONE;
  assign cmd_addr   = (state_q == S_VCMD) ? {line_tag, idx, {OFF_W{1'b0}}}
                                          : {tag_req,  idx, {OFF_W{1'b0}}};
  assign wb_valid   = (state_q == S_WBOUT);
  assign wb_data    = ram_q;
  assign fill_ready = (state_q == S_FILL);
  assign rsp_valid  = (state_q == S_RESP);
  assign rsp_rdata  = write_q ? wdata_q : ram_q;
  assign rsp_hit    = !missed_q;

endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk
  import cache_ctrl_pkg::*;
#(
  parameter int ADDR_W          = 36,
  parameter int DATA_W          = 144,
  parameter int BEATS_LOG2      = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_hit,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [3:0]        cmd_code,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [DATA_W-1:0] wb_data,
  input logic              fill_ready
);
  localparam int BEATS = 1 << BEATS_LOG2;

  logic [3:0]          last_code;
  logic                bus_seen;
  logic [BEATS_LOG2:0] wb_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_code <= CMD_NONE;
      bus_seen  <= 1'b0;
      wb_cnt    <= '0;
    end else begin
      if (req_valid && req_ready) bus_seen <= 1'b0;
      if (cmd_valid && cmd_ready) begin
        last_code <= cmd_code;
        bus_seen  <= 1'b1;
        wb_cnt    <= '0;
      end else if (wb_valid && wb_ready) begin
        wb_cnt <= wb_cnt + 1'b1;
      end
    end
  end

  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_addr));

  assert_wb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_data));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_hit));

  assert_idle_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid && !wb_valid && !fill_ready && !rsp_valid);

  assert_cmd_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_code == CMD_READ_MISS) || (cmd_code == CMD_VICTIM_WR));

  assert_fill_after_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ready |-> last_code == CMD_READ_MISS);

  assert_wb_after_victim_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> last_code == CMD_VICTIM_WR);

  assert_full_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == CMD_READ_MISS |->
      (last_code != CMD_VICTIM_WR) || (wb_cnt == (BEATS_LOG2+1)'(BEATS)));

  assert_hit_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_hit == !bus_seen);

endmodule

bind cache_ctrl cache_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS_LOG2(BEATS_LOG2)
) u_chk (.*);

// File: tb/tb_cache_ctrl.sv
module tb_cache_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [143:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_hit, cmd_valid, wb_valid, fill_ready;
  logic rsp_ready = 1'b0, cmd_ready = 1'b0, wb_ready = 1'b0, fill_valid = 1'b0;
  logic [143:0] rsp_rdata, wb_data;
  logic [143:0] fill_data = '0;
  logic [3:0] cmd_code;
  logic [35:0] cmd_addr;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit bp = 0;

  bit          sh_valid [4];
  bit          sh_dirty [4];
  logic [27:0] sh_tag   [4];
  logic [143:0] sh_data [4][4];
  logic [143:0] mem [logic [35:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_ctrl #(.INDEX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [143:0] memrd(input logic [35:0] blk, input int b);
    logic [35:0] key = blk | (36'(b) << 4);
    if (mem.exists(key)) return mem[key];
    return {key, 4'(b), key ^ 36'h5A5A5A5A5, ~key, 32'hC0FFEE00 | 32'(b)};
  endfunction

  function automatic logic [143:0] wpat(input logic [27:0] tg, input int li, input int bi);
    return {tg, 4'(li), 4'(bi), 108'hFEED_0000 ^ 108'(tg * 31 + 28'(li))};
  endfunction

  task automatic access(input bit wr, input logic [27:0] tg, input int li, input int bi,
                        input logic [143:0] wd, input string rq);
    logic [1:0]   ix = 2'(li);
    logic [1:0]   bt = 2'(bi);
    logic [35:0]  blk = {tg, ix, 6'b0};
    bit           hit;
    int           exp_n = 0, exp_nwb = 0, exp_nfill = 0;
    logic [3:0]   ec [2];
    logic [35:0]  ea [2];
    logic [143:0] ewb [4];
    logic [143:0] erd;
    int           ncmd = 0, nwb = 0, nfill = 0, t = 0;
    bit           got = 0, fire = 0;
    hit = sh_valid[ix] && sh_tag[ix] == tg;
    if (!hit) begin
      if (sh_valid[ix] && sh_dirty[ix]) begin
        ec[0] = 4'h3;
        ea[0] = {sh_tag[ix], ix, 6'b0};
        for (int b = 0; b < 4; b++) begin
          ewb[b] = sh_data[ix][b];
          mem[ea[0] | (36'(b) << 4)] = ewb[b];
        end
        exp_n = 1;
        exp_nwb = 4;
      end
      ec[exp_n] = 4'h1;
      ea[exp_n] = blk;
      exp_n++;
      exp_nfill = 4;
      for (int b = 0; b < 4; b++) sh_data[ix][b] = memrd(blk, b);
      sh_valid[ix] = 1;
      sh_tag[ix]   = tg;
      sh_dirty[ix] = 0;
    end
    if (wr) begin
      sh_data[ix][bt] = wd;
      sh_dirty[ix] = 1;
      erd = wd;
    end else begin
      erd = sh_data[ix][bt];
    end

    req_valid = 1;
    req_write = wr;
    req_addr  = {tg, ix, bt};
    req_wdata = wd;
    while (!got && t < 300) begin
      if (fire) req_valid = 0;
      fire = req_valid && req_ready;
      cmd_ready = !bp || (t % 2 == 1);
      if (cmd_valid && cmd_ready) begin
        if (ncmd < exp_n) begin
          chk(cmd_code == ec[ncmd], ec[ncmd] == 4'h3 ? "R5" : "R4", "cmd_code",
              144'(cmd_code), 144'(ec[ncmd]));
          chk(cmd_addr == ea[ncmd], "R2", "cmd_addr", 144'(cmd_addr), 144'(ea[ncmd]));
        end
        ncmd++;
      end
      wb_ready = !bp || (t % 3 != 0);
      if (wb_valid && wb_ready) begin
        if (nwb < 4) chk(wb_data == ewb[nwb], "R5", "wb_data", wb_data, ewb[nwb]);
        nwb++;
      end
      if (fill_ready && nfill < 4 && (!bp || t % 2 == 0)) begin
        fill_valid = 1;
        fill_data  = memrd(blk, nfill);
        nfill++;
      end else begin
        fill_valid = 0;
      end
      rsp_ready = !bp || (t % 2 == 1);
      if (rsp_valid && rsp_ready) begin
        chk(rsp_hit == hit, rq, "rsp_hit", 144'(rsp_hit), 144'(hit));
        chk(rsp_rdata == erd, wr ? "R8 write" : "R8 read", "rsp_rdata", rsp_rdata, erd);
        got = 1;
      end
      @(negedge clk);
      t++;
    end
    req_valid = 0; cmd_ready = 0; wb_ready = 0; fill_valid = 0; rsp_ready = 0;
    chk(got, "R9", "response seen", 144'(got), 144'(1));
    chk(ncmd == exp_n, hit ? "R3" : (exp_n == 2 ? "R5" : "R10"), "cmd count",
        144'(ncmd), 144'(exp_n));
    chk(nwb == exp_nwb, "R5", "writeback beats", 144'(nwb), 144'(exp_nwb));
    chk(nfill == exp_nfill, "R4", "fill beats", 144'(nfill), 144'(exp_nfill));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      sh_valid[i] = 0;
      sh_dirty[i] = 0;
      sh_tag[i]   = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1", "req_ready", 144'(req_ready), 144'(1));
    chk(cmd_valid == 0, "R1", "cmd_valid", 144'(cmd_valid), 144'(0));
    chk(wb_valid == 0, "R1", "wb_valid", 144'(wb_valid), 144'(0));
    chk(fill_ready == 0, "R1", "fill_ready", 144'(fill_ready), 144'(0));
    chk(rsp_valid == 0, "R1", "rsp_valid", 144'(rsp_valid), 144'(0));

    // R1 cold misses on every line
    for (int l = 0; l < 4; l++) access(0, 28'h0, l, 0, '0, "R1");
    // R2 R3 every beat of every line hits
    for (int l = 0; l < 4; l++)
      for (int b = 0; b < 4; b++) access(0, 28'h0, l, b, '0, "R2 R3");
    // R6 write hits, then read back
    for (int l = 0; l < 4; l++) access(1, 28'h0, l, l, wpat(28'h0, l, l), "R6");
    for (int l = 0; l < 4; l++) access(0, 28'h0, l, l, '0, "R6");
    // R5 dirty eviction by a second tag
    for (int l = 0; l < 4; l++) access(0, 28'h1, l, 3 - l, '0, "R5");
    // R10 clean eviction: no victim
    for (int l = 0; l < 4; l++) access(0, 28'h2, l, 1, '0, "R10");
    // R7 write miss then merge
    for (int l = 0; l < 4; l++) access(1, 28'hABCDEF0, l, 2, wpat(28'hABCDEF0, l, 2), "R7");
    for (int l = 0; l < 4; l++)
      for (int b = 0; b < 4; b++) access(0, 28'hABCDEF0, l, b, '0, "R6");
    // R5 written-back blocks return intact
    for (int l = 0; l < 4; l++) access(0, 28'h0, l, l, '0, "R5");
    // R9 back-pressure sweep over tags, lines and beats
    bp = 1;
    for (int k = 0; k < 3; k++)
      for (int l = 0; l < 4; l++)
        for (int b = 0; b < 4; b++) begin
          logic [27:0] tg = 28'(k * 5 + 3);
          access((b % 2) == 1, tg, l, b, wpat(tg, l, b), "R9");
        end
    bp = 0;
    for (int l = 0; l < 4; l++) access(0, 28'h3, l, 1, '0, "R5");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule